// File: doc/BRIEF.md
# Perturb-and-Observe Maximum Power Point Tracker

This block steers a photovoltaic array towards its maximum power point by nudging a current reference and watching the resulting power. Each accepted voltage sample is multiplied by the current reference that the block is applying at that moment. The product is compared with the power of the previous update. When power went up, the reference moves one more step the same way. When it went down or stayed the same, the direction flips.

The stepped reference then passes a saturation stage. This stage pins it to a programmable ceiling or floor and aims the next step back into range. The step size and both limits come from configuration inputs. Current and voltage are unsigned Q4.12 values, so a code of 4096 means 1.0. Power is kept as the full unsigned Q8.24 product.

An update takes a fixed 36 clock cycles from an accepted sample to the new reference. Samples offered during that time are dropped, so a downstream DC-DC loop sees one reference change per accepted measurement.

Top module: `po_tracker`

## Requirements
- R1: While reset is held, and until the first update, `iref_out` equals `cfg_lo`, `pwr_out` is 0 and `out_valid` is 0. The stored previous power is 0, and the block is pinned at the floor with direction set to increase.
- R2: A sample offered with `smp_valid` high while no update is in flight is accepted. `out_valid` is a single-cycle pulse exactly 36 clock edges after the accepting edge. `iref_out` and `pwr_out` change only in that pulse cycle.
- R3: A sample offered while an update is in flight is ignored, and this includes the edge at which the pending update is applied. It produces no pulse and does not change the result.
- R4: `pwr_out` is the 32-bit product of the accepted `smp_volt` and the `iref_out` value shown at the accepting edge (Q4.12 × Q4.12 = Q8.24).
- R5: When the new power is strictly greater than the previous power, the reference moves by `cfg_step` in the same direction as the last step.
- R6: When the new power is less than or equal to the previous power, the direction reverses before the step is applied.
- R7: A stepped value greater than or equal to `cfg_hi` is replaced by `cfg_hi`. The block becomes pinned with direction set to decrease. This check takes priority over R8.
- R8: A stepped value less than or equal to `cfg_lo` is replaced by `cfg_lo`, and the block becomes pinned with direction set to increase. The update after any pinned update steps in the stored direction regardless of the power comparison.
- R9: On a concave power curve (panel voltage code = 49152 − 2 × reference code, with a peak at reference code 12288) and a step of 82, the reference settles within two steps of the peak.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| smp_valid | input | 1 | Voltage sample strobe |
| smp_volt | input | 16 | Array voltage sample, unsigned Q4.12 |
| cfg_hi | input | 16 | Reference ceiling, Q4.12 |
| cfg_lo | input | 16 | Reference floor, Q4.12 |
| cfg_step | input | 16 | Perturbation step, Q4.12 |
| iref_out | output | 16 | Current reference, Q4.12 |
| pwr_out | output | 32 | Power of the last processed sample, Q8.24 |
| out_valid | output | 1 | One-cycle pulse marking an updated reference |

## Verification
Applying a pending update and offering a fresh sample can fall on the same clock edge. The bench provokes this by raising `smp_valid` in the cycle just before the 36th edge, and also once in the middle of the window. The test passes only if exactly one pulse appears, the reference and power match a single update from the first sample, and no second pulse follows. A reversal and a limit pin can also coincide, so the ceiling and floor tests check that a pinned update overrides the power comparison on the update that follows.

// File: rtl/po_pkg.sv
`timescale 1ns/1ps
package po_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

  function automatic dir_e dir_flip(input dir_e d);
    return (d == DIR_UP) ? DIR_DOWN : DIR_UP;
  endfunction

endpackage

// File: rtl/po_rst_sync.sv
`timescale 1ns/1ps
module po_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/po_timer.sv
`timescale 1ns/1ps
module po_timer #(
  parameter int unsigned LATENCY = 36,
  parameter int unsigned CW      = $clog2(LATENCY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic accept,
  output logic fire
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          idle;

  always_comb begin
    idle   = (cnt_q == '0);
    accept = req && idle;
    fire   = (cnt_q == CW'(LATENCY));
    cnt_d  = cnt_q;
    if (accept) begin
      cnt_d = CW'(1);
    end else if (fire) begin
      cnt_d = '0;
    end else if (!idle) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/po_power.sv
`timescale 1ns/1ps
module po_power #(
  parameter int unsigned DW = 16,
  parameter int unsigned PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] volt,
  input  logic [DW-1:0] iref,
  output logic [PW-1:0] prod
);

  logic [PW-1:0] prod_q;
  logic [PW-1:0] prod_d;

  always_comb begin
    prod_d = PW'(volt) * PW'(iref);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
    end else if (load) begin
      prod_q <= prod_d;
    end
  end

  assign prod = prod_q;

endmodule

// File: rtl/po_stepper.sv
`timescale 1ns/1ps
module po_stepper
  import po_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [PW-1:0] prod,
  input  logic [DW-1:0] cfg_hi,
  input  logic [DW-1:0] cfg_lo,
  input  logic [DW-1:0] cfg_step,
  output logic [DW-1:0] iref_eff,
  output logic [PW-1:0] pwr_last
);

  localparam int unsigned EW = DW + 2;

  logic [DW-1:0] iref_q,   iref_d;
  logic          primed_q, primed_d;
  logic          pinned_q, pinned_d;
  dir_e          dir_q,    dir_d;
  logic [PW-1:0] prev_q,   prev_d;

  logic          rose;
  dir_e          dir_sel;
  logic signed [EW-1:0] cand;
  logic signed [EW-1:0] cur_ext;
  logic signed [EW-1:0] step_ext;
  logic signed [EW-1:0] hi_ext;
  logic signed [EW-1:0] lo_ext;

  assign iref_eff = primed_q ? iref_q : cfg_lo;

  // Decision and saturation stage
  always_comb begin
    rose     = (prod > prev_q);
    cur_ext  = $signed({2'b00, iref_eff});
    step_ext = $signed({2'b00, cfg_step});
    hi_ext   = $signed({2'b00, cfg_hi});
    lo_ext   = $signed({2'b00, cfg_lo});

    if (pinned_q) begin
      dir_sel = dir_q;
    end else if (rose) begin
      dir_sel = dir_q;
    end else begin
      dir_sel = dir_flip(dir_q);
    end

    cand = (dir_sel == DIR_UP) ? (cur_ext + step_ext) : (cur_ext - step_ext);

    primed_d = 1'b1;
    prev_d   = prod;
    if (cand >= hi_ext) begin
      iref_d   = cfg_hi;
      dir_d    = DIR_DOWN;
      pinned_d = 1'b1;
    end else if (cand <= lo_ext) begin
      iref_d   = cfg_lo;
      dir_d    = DIR_UP;
      pinned_d = 1'b1;
    end else begin
      iref_d   = cand[DW-1:0];
      dir_d    = dir_sel;
      pinned_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iref_q   <= '0;
      primed_q <= 1'b0;
      pinned_q <= 1'b1;
      dir_q    <= DIR_UP;
      prev_q   <= '0;
    end else if (fire) begin
      iref_q   <= iref_d;
      primed_q <= primed_d;
      pinned_q <= pinned_d;
      dir_q    <= dir_d;
      prev_q   <= prev_d;
    end
  end

  assign pwr_last = prev_q;

endmodule

// File: rtl/po_tracker.sv
`timescale 1ns/1ps
module po_tracker #(
  parameter int unsigned DW          = 16,
  parameter int unsigned LATENCY     = 36,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_valid,
  input  logic [DW-1:0]   smp_volt,
  input  logic [DW-1:0]   cfg_hi,
  input  logic [DW-1:0]   cfg_lo,
  input  logic [DW-1:0]   cfg_step,
  output logic [DW-1:0]   iref_out,
  output logic [2*DW-1:0] pwr_out,
  output logic            out_valid
);

  localparam int unsigned PW = 2 * DW;
  localparam int unsigned CW = $clog2(LATENCY + 1);

  logic          rst_n_s;
  logic          accept;
  logic          fire;
  logic [PW-1:0] prod;
  logic [DW-1:0] iref_eff;
  logic          ov_q;

  po_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  po_timer #(.LATENCY(LATENCY), .CW(CW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .req    (smp_valid),
    .accept (accept),
    .fire   (fire)
  );

  po_power #(.DW(DW), .PW(PW)) u_power (
    .clk   (clk),
    .rst_n (rst_n_s),
    .load  (accept),
    .volt  (smp_volt),
    .iref  (iref_eff),
    .prod  (prod)
  );

  po_stepper #(.DW(DW), .PW(PW)) u_step (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .fire     (fire),
    .prod     (prod),
    .cfg_hi   (cfg_hi),
    .cfg_lo   (cfg_lo),
    .cfg_step (cfg_step),
    .iref_eff (iref_eff),
    .pwr_last (pwr_out)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ov_q <= 1'b0;
    end else begin
      ov_q <= fire;
    end
  end

  assign iref_out  = iref_eff;
  assign out_valid = ov_q;

endmodule

// File: rtl/po_tracker_chk.sv
`timescale 1ns/1ps
module po_tracker_chk #(
  parameter int unsigned DW      = 16,
  parameter int unsigned LATENCY = 36
) (
  input logic            clk,
  input logic            rst_n,
  input logic            smp_valid,
  input logic [DW-1:0]   cfg_hi,
  input logic [DW-1:0]   cfg_lo,
  input logic [DW-1:0]   cfg_step,
  input logic [DW-1:0]   iref_out,
  input logic [2*DW-1:0] pwr_out,
  input logic            out_valid
);

  localparam int unsigned CW = $clog2(LATENCY + 1);

  // Independent window counter: one accepted sample per window
  logic [CW-1:0] win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else if (win_q == '0) begin
      if (smp_valid) win_q <= CW'(1);
    end else if (win_q == CW'(LATENCY)) begin
      win_q <= '0;
    end else begin
      win_q <= win_q + CW'(1);
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(win_q) == CW'(LATENCY)));

  p_window_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q == CW'(LATENCY)) |=> out_valid);

  p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && $stable(cfg_lo)) |-> ($stable(iref_out) && $stable(pwr_out)));

  p_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((iref_out <= cfg_hi) && (iref_out >= cfg_lo)));

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((iref_out >= $past(iref_out)) ?
                   ((iref_out - $past(iref_out)) <= cfg_step) :
                   (($past(iref_out) - iref_out) <= cfg_step)));

endmodule

bind po_tracker po_tracker_chk #(.DW(DW), .LATENCY(LATENCY)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .cfg_hi    (cfg_hi),
  .cfg_lo    (cfg_lo),
  .cfg_step  (cfg_step),
  .iref_out  (iref_out),
  .pwr_out   (pwr_out),
  .out_valid (out_valid)
);

// File: tb/po_tracker_bench.sv
`timescale 1ns/1ps
module po_tracker_bench;

  logic        clk;
  logic        rst_n;
  logic        smp_valid;
  logic [15:0] smp_volt;
  logic [15:0] cfg_hi;
  logic [15:0] cfg_lo;
  logic [15:0] cfg_step;
  logic [15:0] iref_out;
  logic [31:0] pwr_out;
  logic        out_valid;

  int checks;
  int errors;
  bit done;

  // Reference model state, written from the requirements
  int     m_iref;
  bit     m_primed;
  bit     m_pinned;
  bit     m_up;
  longint m_prev;

  po_tracker u_po_tracker (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_volt  (smp_volt),
    .cfg_hi    (cfg_hi),
    .cfg_lo    (cfg_lo),
    .cfg_step  (cfg_step),
    .iref_out  (iref_out),
    .pwr_out   (pwr_out),
    .out_valid (out_valid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model(input int v, output longint ep, output int ei);
    int     cur;
    bit     d;
    int     cand;
    cur = m_primed ? m_iref : int'(cfg_lo);
    ep  = longint'(v) * longint'(cur);
    if (m_pinned)        d = m_up;
    else if (ep > m_prev) d = m_up;
    else                 d = !m_up;
    cand = d ? cur + int'(cfg_step) : cur - int'(cfg_step);
    if (cand >= int'(cfg_hi)) begin
      m_iref = cfg_hi; m_up = 1'b0; m_pinned = 1'b1;
    end else if (cand <= int'(cfg_lo)) begin
      m_iref = cfg_lo; m_up = 1'b1; m_pinned = 1'b1;
    end else begin
      m_iref = cand; m_up = d; m_pinned = 1'b0;
    end
    m_primed = 1'b1;
    m_prev   = ep;
    ei       = m_iref;
  endtask

  task automatic do_reset(input int lo, input int hi, input int step);
    @(negedge clk);
    rst_n     = 1'b0;
    smp_valid = 1'b0;
    smp_volt  = '0;
    cfg_lo    = 16'(lo);
    cfg_hi    = 16'(hi);
    cfg_step  = 16'(step);
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", out_valid, 0);
    check("R1 pwr_out in reset", pwr_out, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_iref = lo; m_primed = 0; m_pinned = 1; m_up = 1; m_prev = 0;
  endtask

  task automatic sample(input int v, input string tag, input int exp_lit);
    longint ep;
    int     ei;
    int     n;
    model(v, ep, ei);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_volt  = 16'(v);
    @(negedge clk);
    smp_valid = 1'b0;
    n = 0;
    while (!out_valid && n < 100) begin
      @(negedge clk);
      n++;
    end
    check({"R2 latency ", tag}, n, 36);
    check({"R4 power ", tag}, pwr_out, ep);
    check({tag, " reference"}, iref_out, ei);
    if (exp_lit >= 0) check({tag, " reference literal"}, iref_out, exp_lit);
    @(negedge clk);
    check("R2 single pulse", out_valid, 0);
  endtask

  task automatic t_reset();
    do_reset(4096, 20480, 82);
    check("R1 reference follows floor", iref_out, 4096);
    check("R1 power zero", pwr_out, 0);
    check("R1 no pulse", out_valid, 0);
  endtask

  task automatic t_directions();
    do_reset(4096, 20480, 82);
    sample(8192, "R8 first step up from pinned floor", 4178);
    sample(8192, "R5 rose keeps direction", 4260);
    sample(0,    "R6 fell reverses", 4178);
    sample(0,    "R6 equal reverses", 4260);
    sample(12000, "R5 rose again", 4342);
  endtask

  task automatic t_ceiling();
    do_reset(0, 200, 82);
    sample(1000, "R8 leave floor", 82);
    sample(2000, "R5 climb", 164);
    sample(3000, "R7 pinned at ceiling", 200);
    sample(4000, "R8 pinned overrides rise", 118);
    sample(100,  "R7 reverse back to ceiling", 200);
  endtask

  task automatic t_floor();
    do_reset(1000, 20000, 82);
    sample(5000, "R5 first step", 1082);
    sample(1000, "R8 pinned at floor", 1000);
    sample(1,    "R8 pinned overrides fall", 1082);
  endtask

  task automatic t_collision();
    longint ep;
    int     ei;
    int     pulses;
    do_reset(0, 20480, 82);
    model(9000, ep, ei);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_volt  = 16'd9000;
    @(negedge clk);
    smp_valid = 1'b0;
    for (int n = 1; n <= 36; n++) begin
      @(negedge clk);
      if (n == 10 || n == 35) begin
        smp_valid = 1'b1;
        smp_volt  = 16'(n * 1000);
      end else begin
        smp_valid = 1'b0;
      end
      if (n < 36) check("R3 no early pulse", out_valid, 0);
    end
    smp_valid = 1'b0;
    check("R3 pulse at update edge", out_valid, 1);
    check("R3 reference from first sample", iref_out, ei);
    check("R3 power from first sample", pwr_out, ep);
    pulses = 0;
    for (int n = 0; n < 60; n++) begin
      @(negedge clk);
      if (out_valid) pulses++;
    end
    check("R3 ignored samples make no pulse", pulses, 0);
    check("R3 reference unchanged", iref_out, ei);
  endtask

  task automatic t_converge();
    int dev;
    do_reset(0, 20480, 82);
    for (int k = 0; k < 250; k++) begin
      sample(49152 - 2 * int'(iref_out), "R9 track", -1);
    end
    for (int k = 0; k < 8; k++) begin
      sample(49152 - 2 * int'(iref_out), "R9 settle", -1);
      dev = int'(iref_out) - 12288;
      if (dev < 0) dev = -dev;
      check("R9 within two steps of peak", (dev <= 164) ? 1 : 0, 1);
    end
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; smp_valid = 1'b0; smp_volt = '0;
    cfg_lo = '0; cfg_hi = 16'd20480; cfg_step = 16'd82;
    t_reset();
    t_directions();
    t_ceiling();
    t_floor();
    t_collision();
    t_converge();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule